// File: doc/BRIEF.md
# Message-Signalled Interrupt Dispatcher with Pending Replay

This block sits between a function's interrupt sources and its outbound write path. Each interrupt request names a vector. Using the capability state that the register decoder hands it, the block builds one single-dword memory-write message per request. The message address is either the full 64-bit address or the 32-bit address, depending on whether the function advertises 64-bit addressing. The message data is the 16-bit data field zero-extended to 32 bits. When several vectors are enabled, its low bits carry the vector number.

When per-vector masking is supported and a request targets a masked vector, no message goes out. The block sets that vector's pending bit instead. A configuration write while signalling is enabled does two things. First it trims pending bits that lie outside the enabled vector range. Then it scans the vectors from 0 upward, and every vector that is pending and now unmasked is cleared and sent. Requests are held off while this scan runs and while a message waits for the downstream side. While message signalling is enabled, the legacy level interrupt output is forced inactive.

Top module: `msi_dispatch`

## Requirements
- R1: With masking supported and signalling enabled, an in-range request whose mask bit is set sets bit `vec` of `pending_o` in the cycle after acceptance and produces no message.
- R2: An accepted, in-range, unmasked request while enabled raises `msg_valid_o` in the cycle after acceptance. `msg_addr_o` is `{cfg_addr_hi_i, cfg_addr_lo_i}` when `cfg_addr64_i` is 1, and `{32'h0, cfg_addr_lo_i}` when it is 0.
- R3: `msg_data_o[31:16]` is zero and `msg_data_o[15:0]` is `cfg_data_i`. When `cfg_vec_log2_i` = k > 0, bits k-1:0 are replaced by the vector number.
- R4: While `msg_valid_o` is high and `msg_ready_i` is low, the message stays valid and its address and data do not change. The message is consumed on a clock edge where `msg_ready_i` is high.
- R5: A request with `vec >= 2**cfg_vec_log2_i` is accepted and dropped. `req_err_o` pulses for one cycle, and no message or pending bit results.
- R6: A `cfg_wr_i` pulse while enabled with masking supported clears every pending bit at or above the enabled vector count. The trimmed value is visible in the cycle after the pulse.
- R7: After that pulse, each vector below the enabled count that is pending and unmasked has its pending bit cleared and is sent. Vectors go out one message at a time in ascending order. Pending vectors that are still masked stay pending.
- R8: Without masking support (`cfg_mask_cap_i` = 0), mask bits are ignored and requests are sent, `pending_o` stays zero, and `cfg_wr_i` starts no scan.
- R9: `req_ready_o` is low while a scan is running, while a message is held, and during a `cfg_wr_i` pulse.
- R10: `intx_o` is 0 while `cfg_en_i` is 1, and follows `intx_req_i` while `cfg_en_i` is 0.
- R11: A request accepted while `cfg_en_i` is 0 is dropped. It sets no pending bit, sends no message and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Message signalling enabled |
| cfg_addr64_i | input | 1 | 64-bit address supported |
| cfg_mask_cap_i | input | 1 | Per-vector masking supported |
| cfg_vec_log2_i | input | LW (3) | log2 of enabled vector count; values above MAX_LOG2 are clamped |
| cfg_addr_lo_i | input | 32 | Message address, low dword |
| cfg_addr_hi_i | input | 32 | Message address, high dword |
| cfg_data_i | input | 16 | Message data field |
| cfg_mask_i | input | NV (32) | Per-vector mask bits |
| cfg_wr_i | input | 1 | One-cycle strobe: capability configuration was written |
| req_valid_i | input | 1 | Interrupt request valid |
| req_vec_i | input | VW (5) | Requested vector number |
| req_ready_o | output | 1 | Request can be accepted |
| req_err_o | output | 1 | One-cycle pulse: out-of-range request dropped |
| msg_valid_o | output | 1 | Write message valid |
| msg_ready_i | input | 1 | Write message taken |
| msg_addr_o | output | 64 | Write message address |
| msg_data_o | output | 32 | Write message data |
| pending_o | output | NV (32) | Pending vector bits |
| intx_req_i | input | 1 | Legacy level interrupt request |
| intx_o | output | 1 | Legacy level interrupt output |

## Verification
Several properties are checked on every clock. A held message must stay stable until it is taken. Requests must stall while a scan runs. A masked request must set its pending bit. A configuration write must leave no pending bit above the enabled range. Loss of masking support must empty the pending register. An error pulse must never come with a new message. The correct composition of address and data in each width mode, the ascending replay order, vectors that stay masked and remain pending, and dropped requests while disabled can only be shown by the bench's scenarios, which compare the message stream against values worked out from the requirements.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_st_e;
endpackage

// File: rtl/msi_msg_fmt.sv
module msi_msg_fmt #(
  parameter int unsigned VW = 5
) (
  input  logic          addr64_i,
  input  logic [31:0]   addr_lo_i,
  input  logic [31:0]   addr_hi_i,
  input  logic [15:0]   data_i,
  input  logic [VW-1:0] low_mask_i,
  input  logic [VW-1:0] vec_i,
  output logic [63:0]   addr_o,
  output logic [31:0]   data_o
);
  always_comb begin
    addr_o = addr64_i ? {addr_hi_i, addr_lo_i} : {32'h0, addr_lo_i};
    data_o = {16'h0, data_i};
    // vector number replaces the low log2(count) bits
    data_o[VW-1:0] = (data_i[VW-1:0] & ~low_mask_i) | (vec_i & low_mask_i);
  end
endmodule

// File: rtl/msi_pend_scan.sv
module msi_pend_scan
  import msi_pkg::*;
#(
  parameter int unsigned NV = 32,
  parameter int unsigned VW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mask_cap_i,
  input  logic          set_i,
  input  logic [VW-1:0] set_vec_i,
  input  logic          start_i,
  input  logic [NV-1:0] keep_i,
  input  logic [NV-1:0] mask_i,
  input  logic [VW-1:0] last_vec_i,
  input  logic          slot_free_i,
  output logic [NV-1:0] pending_o,
  output logic          busy_o,
  output logic          hit_o,
  output logic [VW-1:0] hit_vec_o
);
  scan_st_e      st_q;
  logic [VW-1:0] idx_q;
  logic [NV-1:0] pend_q;

  assign busy_o    = (st_q == SCAN_RUN);
  assign hit_vec_o = idx_q;
  assign hit_o     = busy_o && slot_free_i && pend_q[idx_q] && !mask_i[idx_q];
  assign pending_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SCAN_IDLE;
      idx_q  <= '0;
      pend_q <= '0;
    end else if (!mask_cap_i) begin
      st_q   <= SCAN_IDLE;
      idx_q  <= '0;
      pend_q <= '0;
    end else if (start_i) begin
      pend_q <= pend_q & keep_i;
      st_q   <= SCAN_RUN;
      idx_q  <= '0;
    end else begin
      if (set_i) pend_q[set_vec_i] <= 1'b1;
      if (busy_o && slot_free_i) begin
        if (hit_o) pend_q[idx_q] <= 1'b0;
        if (idx_q == last_vec_i) st_q <= SCAN_IDLE;
        else idx_q <= idx_q + 1'b1;
      end
    end
  end

  p_pend_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && mask_cap_i && !start_i |=> pend_q[$past(set_vec_i)]);

  p_trim_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && mask_cap_i |=> (pend_q & ~$past(keep_i)) == '0);

  p_nocap_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_cap_i |=> (pend_q == '0) && !busy_o);
endmodule

// File: rtl/msi_dispatch.sv
module msi_dispatch #(
  parameter int unsigned MAX_LOG2 = 5,
  localparam int unsigned NV = 1 << MAX_LOG2,
  localparam int unsigned VW = MAX_LOG2,
  localparam int unsigned LW = $clog2(MAX_LOG2 + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_en_i,
  input  logic          cfg_addr64_i,
  input  logic          cfg_mask_cap_i,
  input  logic [LW-1:0] cfg_vec_log2_i,
  input  logic [31:0]   cfg_addr_lo_i,
  input  logic [31:0]   cfg_addr_hi_i,
  input  logic [15:0]   cfg_data_i,
  input  logic [NV-1:0] cfg_mask_i,
  input  logic          cfg_wr_i,
  input  logic          req_valid_i,
  input  logic [VW-1:0] req_vec_i,
  output logic          req_ready_o,
  output logic          req_err_o,
  output logic          msg_valid_o,
  input  logic          msg_ready_i,
  output logic [63:0]   msg_addr_o,
  output logic [31:0]   msg_data_o,
  output logic [NV-1:0] pending_o,
  input  logic          intx_req_i,
  output logic          intx_o
);
  logic [LW-1:0] log2_eff;
  logic [VW:0]   low_mask_full;
  logic [VW-1:0] low_mask;
  logic [NV:0]   keep_full;
  logic [NV-1:0] keep;
  logic          in_range, masked, accept, launch_req, set_pend, start_scan;
  logic          scan_busy, scan_hit;
  logic [VW-1:0] scan_vec, fmt_vec;
  logic [63:0]   fmt_addr;
  logic [31:0]   fmt_data;
  logic          msg_valid_q, err_q;
  logic [63:0]   msg_addr_q;
  logic [31:0]   msg_data_q;

  assign log2_eff      = (cfg_vec_log2_i > LW'(MAX_LOG2)) ? LW'(MAX_LOG2) : cfg_vec_log2_i;
  assign low_mask_full = ({{VW{1'b0}}, 1'b1} << log2_eff) - 1'b1;
  assign low_mask      = low_mask_full[VW-1:0];
  assign keep_full     = ({{NV{1'b0}}, 1'b1} << (1 << log2_eff)) - 1'b1;
  assign keep          = keep_full[NV-1:0];

  assign in_range    = (req_vec_i & ~low_mask) == '0;
  assign masked      = cfg_mask_cap_i && cfg_mask_i[req_vec_i];
  assign req_ready_o = !scan_busy && !msg_valid_q && !cfg_wr_i;
  assign accept      = req_valid_i && req_ready_o;
  assign launch_req  = accept && cfg_en_i && in_range && !masked;
  assign set_pend    = accept && cfg_en_i && in_range && masked;
  assign start_scan  = cfg_wr_i && cfg_en_i && cfg_mask_cap_i;
  assign fmt_vec     = scan_hit ? scan_vec : req_vec_i;

  msi_pend_scan #(.NV(NV), .VW(VW)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mask_cap_i (cfg_mask_cap_i),
    .set_i      (set_pend),
    .set_vec_i  (req_vec_i),
    .start_i    (start_scan),
    .keep_i     (keep),
    .mask_i     (cfg_mask_i),
    .last_vec_i (low_mask),
    .slot_free_i(!msg_valid_q),
    .pending_o  (pending_o),
    .busy_o     (scan_busy),
    .hit_o      (scan_hit),
    .hit_vec_o  (scan_vec)
  );

  msi_msg_fmt #(.VW(VW)) u_fmt (
    .addr64_i  (cfg_addr64_i),
    .addr_lo_i (cfg_addr_lo_i),
    .addr_hi_i (cfg_addr_hi_i),
    .data_i    (cfg_data_i),
    .low_mask_i(low_mask),
    .vec_i     (fmt_vec),
    .addr_o    (fmt_addr),
    .data_o    (fmt_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_valid_q <= 1'b0;
      msg_addr_q  <= '0;
      msg_data_q  <= '0;
      err_q       <= 1'b0;
    end else begin
      err_q <= accept && cfg_en_i && !in_range;
      if (launch_req || scan_hit) begin
        msg_valid_q <= 1'b1;
        msg_addr_q  <= fmt_addr;
        msg_data_q  <= fmt_data;
      end else if (msg_ready_i) begin
        msg_valid_q <= 1'b0;
      end
    end
  end

  assign msg_valid_o = msg_valid_q;
  assign msg_addr_o  = msg_addr_q;
  assign msg_data_o  = msg_data_q;
  assign req_err_o   = err_q;
  assign intx_o      = intx_req_i && !cfg_en_i;

  p_msg_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o));

  p_scan_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_busy |-> !req_ready_o);

  p_err_no_msg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_err_o |-> !msg_valid_o);
endmodule

// File: tb/msi_dispatch_tb_top.sv
module msi_dispatch_tb_top;
  localparam logic [1:0] K_NONE = 2'd0, K_MSG = 2'd1, K_PEND = 2'd2, K_ERR = 2'd3;
  localparam logic [31:0] A_LO = 32'hFEE0_1000;
  localparam logic [31:0] A_HI = 32'h0000_0001;
  localparam logic [15:0] DAT  = 16'h4A37;
  localparam logic [63:0] A32  = {32'h0, A_LO};
  localparam logic [63:0] A64  = {A_HI, A_LO};

  typedef struct packed {
    logic        en;
    logic        a64;
    logic        mcap;
    logic [2:0]  lg;
    logic        mk;
    logic [4:0]  vec;
    logic [1:0]  kind;
    logic [31:0] pend;
    logic [63:0] addr;
    logic [31:0] data;
  } case_t;

  localparam int NCASE = 9;
  localparam case_t TBL [NCASE] = '{
    '{1'b1, 1'b0, 1'b1, 3'd0, 1'b0, 5'd0,  K_MSG,  32'h0,  A32,   32'h4A37}, // R2 R3
    '{1'b1, 1'b1, 1'b1, 3'd3, 1'b0, 5'd5,  K_MSG,  32'h0,  A64,   32'h4A35}, // R2 R3
    '{1'b1, 1'b1, 1'b0, 3'd5, 1'b0, 5'd31, K_MSG,  32'h0,  A64,   32'h4A3F}, // R3
    '{1'b1, 1'b0, 1'b1, 3'd2, 1'b0, 5'd2,  K_MSG,  32'h0,  A32,   32'h4A36}, // R3
    '{1'b1, 1'b0, 1'b1, 3'd3, 1'b1, 5'd4,  K_PEND, 32'h10, 64'h0, 32'h0},    // R1
    '{1'b1, 1'b0, 1'b0, 3'd3, 1'b1, 5'd4,  K_MSG,  32'h0,  A32,   32'h4A34}, // R8
    '{1'b0, 1'b0, 1'b1, 3'd3, 1'b1, 5'd4,  K_NONE, 32'h0,  64'h0, 32'h0},    // R11
    '{1'b1, 1'b0, 1'b1, 3'd2, 1'b0, 5'd4,  K_ERR,  32'h0,  64'h0, 32'h0},    // R5
    '{1'b1, 1'b1, 1'b1, 3'd0, 1'b0, 5'd1,  K_ERR,  32'h0,  64'h0, 32'h0}     // R5
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_en_i = 1'b0, cfg_addr64_i = 1'b0, cfg_mask_cap_i = 1'b0;
  logic [2:0]  cfg_vec_log2_i = '0;
  logic [31:0] cfg_addr_lo_i = A_LO, cfg_addr_hi_i = A_HI;
  logic [15:0] cfg_data_i = DAT;
  logic [31:0] cfg_mask_i = '0;
  logic        cfg_wr_i = 1'b0, req_valid_i = 1'b0, msg_ready_i = 1'b0, intx_req_i = 1'b0;
  logic [4:0]  req_vec_i = '0;
  logic        req_ready_o, req_err_o, msg_valid_o, intx_o;
  logic [63:0] msg_addr_o;
  logic [31:0] msg_data_o;
  logic [31:0] pending_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  msi_dispatch dut_i (
    .clk_i, .rst_ni, .cfg_en_i, .cfg_addr64_i, .cfg_mask_cap_i, .cfg_vec_log2_i,
    .cfg_addr_lo_i, .cfg_addr_hi_i, .cfg_data_i, .cfg_mask_i, .cfg_wr_i,
    .req_valid_i, .req_vec_i, .req_ready_o, .req_err_o, .msg_valid_o, .msg_ready_i,
    .msg_addr_o, .msg_data_o, .pending_o, .intx_req_i, .intx_o
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic send_req(input logic [4:0] v);
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_vec_i = v;
    #1;
    while (!req_ready_o) begin
      @(negedge clk_i);
      #1;
    end
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic pulse_cfg_wr();
    @(negedge clk_i);
    cfg_wr_i = 1'b1;
    @(negedge clk_i);
    cfg_wr_i = 1'b0;
  endtask

  task automatic take_msg(input string tag, input logic [31:0] exp_data);
    int k = 0;
    while (!msg_valid_o && k < 20) begin
      @(negedge clk_i);
      k++;
    end
    chk({tag, " valid"}, 64'(msg_valid_o), 64'd1);
    chk({tag, " data"}, 64'(msg_data_o), 64'(exp_data));
    msg_ready_i = 1'b1;
    @(negedge clk_i);
    msg_ready_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    chk("reset msg_valid", 64'(msg_valid_o), 64'd0);
    chk("reset pending", 64'(pending_o), 64'd0);
    chk("reset err", 64'(req_err_o), 64'd0);
    chk("reset ready R9", 64'(req_ready_o), 64'd1);

    for (int i = 0; i < NCASE; i++) begin
      do_reset();
      cfg_en_i = TBL[i].en;
      cfg_addr64_i = TBL[i].a64;
      cfg_mask_cap_i = TBL[i].mcap;
      cfg_vec_log2_i = TBL[i].lg;
      cfg_mask_i = TBL[i].mk ? (32'd1 << TBL[i].vec) : 32'd0;
      send_req(TBL[i].vec);
      #1;
      chk($sformatf("case%0d R2 valid", i), 64'(msg_valid_o), 64'(TBL[i].kind == K_MSG));
      chk($sformatf("case%0d R1 pending", i), 64'(pending_o), 64'(TBL[i].pend));
      chk($sformatf("case%0d R5 err", i), 64'(req_err_o), 64'(TBL[i].kind == K_ERR));
      if (TBL[i].kind == K_MSG) begin
        chk($sformatf("case%0d R2 addr", i), msg_addr_o, TBL[i].addr);
        chk($sformatf("case%0d R3 data", i), 64'(msg_data_o), 64'(TBL[i].data));
        msg_ready_i = 1'b1;
        @(negedge clk_i);
        msg_ready_i = 1'b0;
      end
    end

    // R4 / R9: held message stays stable, requests stall
    do_reset();
    cfg_en_i = 1'b1; cfg_addr64_i = 1'b0; cfg_mask_cap_i = 1'b1;
    cfg_vec_log2_i = 3'd0; cfg_mask_i = '0;
    send_req(5'd0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk_i);
      chk("R4 held valid", 64'(msg_valid_o), 64'd1);
      chk("R4 held data", 64'(msg_data_o), 64'h4A37);
      chk("R9 ready low while held", 64'(req_ready_o), 64'd0);
    end
    msg_ready_i = 1'b1;
    @(negedge clk_i);
    msg_ready_i = 1'b0;
    chk("R4 consumed", 64'(msg_valid_o), 64'd0);

    // R6 / R7: trim and flush
    do_reset();
    cfg_en_i = 1'b1; cfg_mask_cap_i = 1'b1; cfg_vec_log2_i = 3'd3; cfg_mask_i = 32'hFF;
    send_req(5'd1);
    send_req(5'd6);
    send_req(5'd3);
    #1;
    chk("R1 three pending", 64'(pending_o), 64'h4A);
    cfg_vec_log2_i = 3'd2;
    cfg_mask_i = 32'h08;
    @(negedge clk_i);
    cfg_wr_i = 1'b1;
    #1;
    chk("R9 ready low during cfg_wr", 64'(req_ready_o), 64'd0);
    @(negedge clk_i);
    cfg_wr_i = 1'b0;
    #1;
    chk("R6 trimmed", 64'(pending_o), 64'h0A);
    chk("R9 ready low in scan", 64'(req_ready_o), 64'd0);
    take_msg("R7 flush vec1", 32'h4A35);
    repeat (10) @(negedge clk_i);
    chk("R7 masked stays pending", 64'(pending_o), 64'h08);
    chk("R7 no extra msg", 64'(msg_valid_o), 64'd0);
    cfg_mask_i = '0;
    pulse_cfg_wr();
    take_msg("R7 flush vec3", 32'h4A37);
    repeat (10) @(negedge clk_i);
    chk("R7 pending empty", 64'(pending_o), 64'h0);

    // R7: ascending order
    cfg_mask_i = 32'h0F;
    send_req(5'd2);
    send_req(5'd0);
    cfg_mask_i = '0;
    pulse_cfg_wr();
    take_msg("R7 order first vec0", 32'h4A34);
    take_msg("R7 order second vec2", 32'h4A36);

    // R8: no scan without masking support
    do_reset();
    cfg_en_i = 1'b1; cfg_mask_cap_i = 1'b0; cfg_vec_log2_i = 3'd2; cfg_mask_i = 32'hF;
    send_req(5'd1);
    #1;
    chk("R8 masked ignored sends", 64'(msg_valid_o), 64'd1);
    msg_ready_i = 1'b1;
    @(negedge clk_i);
    msg_ready_i = 1'b0;
    pulse_cfg_wr();
    repeat (5) @(negedge clk_i);
    chk("R8 no flush msg", 64'(msg_valid_o), 64'd0);
    chk("R8 ready after wr", 64'(req_ready_o), 64'd1);
    chk("R8 pending zero", 64'(pending_o), 64'd0);

    // R10: legacy line
    intx_req_i = 1'b1;
    cfg_en_i = 1'b1;
    #1;
    chk("R10 forced low when enabled", 64'(intx_o), 64'd0);
    cfg_en_i = 1'b0;
    #1;
    chk("R10 follows when disabled", 64'(intx_o), 64'd1);
    intx_req_i = 1'b0;
    #1;
    chk("R10 follows low", 64'(intx_o), 64'd0);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule